// File: doc/BRIEF.md
# Fixed-Code Literal/Length Symbol Decoder

This block turns the head of a compressed bit stream into one literal/length symbol of the fixed (static) Huffman code used by DEFLATE blocks of type 1. A bit reader upstream presents a window of at least nine stream bits. Bit 0 of the window is the next bit of the stream, which is the most significant bit of the code. The block returns three things: the symbol value (0 to 287), the number of code bits to consume (7, 8 or 9), and a flag for the two symbols that have codes but must never appear.

The decode needs no tree walk. The five leading code bits choose one of 32 prefix entries, and each entry holds a code length and a signed offset. The symbol is the code value, read at that length, plus the offset. Symbols 256 to 279 have 7-bit codes and take offset +256. Symbols 0 to 143 have 8-bit codes and take offset −48. Symbols 280 to 287 have 8-bit codes and take offset +88. Symbols 144 to 255 have 9-bit codes and take offset −256.

The lookup and the add form one combinational path. A parameter either places one register stage after it or leaves the outputs combinational. The consumer feeds the returned length back into its bit reader.

Top module: `fxd_litlen_decoder`

## Requirements
- R1: Window bit 0 is the first and most significant code bit, and bit i is code bit i counted from the front. Window bits at index 9 and above never change any output. Bits beyond the code length also never change any output.
- R2: The 7-bit codes 0000000 to 0010111 decode to symbols 256 to 279, where the symbol equals the code value plus 256. The reported length is 7.
- R3: The 8-bit codes 00110000 to 10111111 decode to symbols 0 to 143, where the symbol equals the code value minus 48. The reported length is 8.
- R4: The 8-bit codes 11000000 to 11000111 decode to symbols 280 to 287, where the symbol equals the code value plus 88. The reported length is 8.
- R5: The 9-bit codes 110010000 to 111111111 decode to symbols 144 to 255, where the symbol equals the code value minus 256. The reported length is 9.
- R6: The invalid flag is 1 exactly when the decoded symbol is 286 or 287, which are codes 11000110 and 11000111. In that case the symbol and a length of 8 are still reported.
- R7: With the register stage enabled, each window sampled with in_valid high produces its results and out_valid high at the next rising clock edge. After a cycle with in_valid low, out_valid is 0 and the symbol, length and flag outputs keep their previous values.
- R8: While rst is high at a clock edge, out_valid, out_sym, out_len and out_bad are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Window holds bits to decode this cycle |
| win | input | WIN_W (16) | Stream bits; bit 0 is the next bit |
| out_valid | output | 1 | Decoded result present |
| out_sym | output | 9 | Decoded literal/length symbol |
| out_len | output | 4 | Code length to consume (7, 8 or 9) |
| out_bad | output | 1 | Symbol is 286 or 287 |

## Verification
With the default register stage, every result is due at the first rising edge after the window is presented. The bench drives each window on a falling edge and reads the outputs on the next falling edge, so each read lands half a cycle after the edge that produced the result. The hold check leaves in_valid low for one edge and then reads out_valid and the held data in the same place. The reset check reads at a falling edge while reset is still high.

// File: rtl/fxd_pkg.sv
package fxd_pkg;

  localparam int CODE_MAX_W = 9;
  localparam int SYM_W      = 9;
  localparam int LEN_W      = 4;
  localparam int OFS_W      = 10;
  localparam int PFX_W      = 5;

  // One prefix entry: code length and two's-complement offset
  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic [OFS_W-1:0] ofs;
  } fxd_entry_t;

  // Build the entry for one 5-bit prefix value
  function automatic fxd_entry_t fxd_entry(input int pfx);
    fxd_entry_t e;
    if (pfx < 6) begin
      e.len = LEN_W'(7);
      e.ofs = OFS_W'(256);
    end else if (pfx < 24) begin
      e.len = LEN_W'(8);
      e.ofs = OFS_W'(-48);
    end else if (pfx == 24) begin
      e.len = LEN_W'(8);
      e.ofs = OFS_W'(88);
    end else begin
      e.len = LEN_W'(9);
      e.ofs = OFS_W'(-256);
    end
    return e;
  endfunction

endpackage

// File: rtl/fxd_prefix_rom.sv
module fxd_prefix_rom
  import fxd_pkg::*;
#(
  parameter int IDX_W = PFX_W
) (
  input  logic [IDX_W-1:0] idx,
  output fxd_entry_t       ent
);

  localparam int ENTRIES = 1 << IDX_W;

  fxd_entry_t tbl [ENTRIES];

  // Table contents are computed per prefix, not written out
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign tbl[g] = fxd_entry(g << (PFX_W - IDX_W));
  end

  assign ent = tbl[idx];

endmodule

// File: rtl/fxd_sym_build.sv
module fxd_sym_build
  import fxd_pkg::*;
(
  input  logic [CODE_MAX_W-1:0] code9,
  input  fxd_entry_t            ent,
  output logic [SYM_W-1:0]      sym,
  output logic                  bad
);

  logic [OFS_W-1:0] base;
  logic [OFS_W-1:0] sum;

  // Read the code value at the length the prefix selected
  always_comb begin
    unique case (ent.len)
      LEN_W'(7): base = OFS_W'(code9[CODE_MAX_W-1:2]);
      LEN_W'(8): base = OFS_W'(code9[CODE_MAX_W-1:1]);
      default:   base = OFS_W'(code9);
    endcase
  end

  assign sum = base + ent.ofs;
  assign sym = sum[SYM_W-1:0];

  // Unused symbols 286/287 are found from the code bits themselves
  assign bad = (code9[CODE_MAX_W-1:2] == 7'b1100011);

endmodule

// File: rtl/fxd_out_stage.sv
module fxd_out_stage #(
  parameter int  W       = 14,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q_valid <= 1'b0;
        q       <= '0;
      end else begin
        q_valid <= d_valid;
        if (d_valid) q <= d;
      end
    end

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
      d_valid |=> q_valid);
    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !d_valid |=> (!q_valid && $stable(q)));
    assert_reset_clears_R8: assert property (@(posedge clk)
      $past(rst) |-> (!q_valid && q == '0));
  end else begin : g_comb
    assign q_valid = d_valid;
    assign q       = d;
  end

endmodule

// File: rtl/fxd_litlen_decoder.sv
module fxd_litlen_decoder
  import fxd_pkg::*;
#(
  parameter int WIN_W   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIN_W-1:0] win,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_sym,
  output logic [LEN_W-1:0] out_len,
  output logic             out_bad
);

  localparam int DATA_W = SYM_W + LEN_W + 1;

  logic [CODE_MAX_W-1:0] code9;
  fxd_entry_t            ent;
  logic [SYM_W-1:0]      sym_c;
  logic                  bad_c;
  logic [DATA_W-1:0]     q;

  // Window bit 0 is the code MSB: reverse the leading nine bits
  for (genvar i = 0; i < CODE_MAX_W; i++) begin : g_rev
    assign code9[CODE_MAX_W-1-i] = win[i];
  end

  fxd_prefix_rom #(.IDX_W(PFX_W)) u_rom (
    .idx (code9[CODE_MAX_W-1 -: PFX_W]),
    .ent (ent)
  );

  fxd_sym_build u_build (
    .code9 (code9),
    .ent   (ent),
    .sym   (sym_c),
    .bad   (bad_c)
  );

  fxd_out_stage #(.W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d       ({sym_c, ent.len, bad_c}),
    .q_valid (out_valid),
    .q       (q)
  );

  assign {out_sym, out_len, out_bad} = q;

  // Length class and symbol range must agree (R2..R5)
  assert_len_legal_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len == 4'd7 || out_len == 4'd8 || out_len == 4'd9));
  assert_len7_range_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == 4'd7) |-> (out_sym >= 9'd256 && out_sym <= 9'd279));
  assert_len8_range_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == 4'd8) |-> (out_sym <= 9'd143 || out_sym >= 9'd280));
  assert_len9_range_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_len == 4'd9) |-> (out_sym >= 9'd144 && out_sym <= 9'd255));
  assert_bad_matches_sym_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_bad == (out_sym >= 9'd286)));

endmodule

// File: tb/fxd_litlen_decoder_bench.sv
`timescale 1ns/1ps
module fxd_litlen_decoder_bench;

  localparam int WIN_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [WIN_W-1:0] win = '0;
  logic             out_valid;
  logic [8:0]       out_sym;
  logic [3:0]       out_len;
  logic             out_bad;

  int n_chk = 0;
  int n_bad = 0;
  logic [WIN_W-1:0] fill = 16'hACE1;

  always #4 clk = ~clk;

  fxd_litlen_decoder #(.WIN_W(WIN_W), .REG_OUT(1'b1)) u_fxd_litlen_decoder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .win(win),
    .out_valid(out_valid), .out_sym(out_sym), .out_len(out_len), .out_bad(out_bad)
  );

  task automatic check(input string req, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [WIN_W-1:0] next_fill(input logic [WIN_W-1:0] f);
    return {f[WIN_W-2:0], f[15] ^ f[13] ^ f[12] ^ f[10]};
  endfunction

  // Place the code MSB-first at window bit 0; stream bits after it come from fill
  function automatic logic [WIN_W-1:0] make_win(input int code, input int len,
                                                input logic [WIN_W-1:0] f);
    logic [WIN_W-1:0] w;
    w = f;
    for (int i = 0; i < len; i++) w[i] = code[len-1-i];
    return w;
  endfunction

  // Present one window, read the result one edge later
  task automatic decode(input logic [WIN_W-1:0] w, input string req,
                        input int esym, input int elen, input int ebad);
    @(negedge clk);
    win = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_valid, 1, "out_valid");
    check(req, out_sym, esym, "symbol");
    check(req, out_len, elen, "length");
    check(req, out_bad, ebad, "invalid flag");
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8", out_valid, 0, "out_valid in reset");
    check("R8", out_sym, 0, "sym in reset");
    check("R8", out_len, 0, "len in reset");
    check("R8", out_bad, 0, "bad in reset");
    rst = 1'b0;
  endtask

  task automatic t_seven; // R2
    for (int s = 256; s <= 279; s++) begin
      fill = next_fill(fill);
      decode(make_win(s - 256, 7, fill), "R2", s, 7, 0);
    end
  endtask

  task automatic t_eight_lo; // R3
    for (int s = 0; s <= 143; s++) begin
      fill = next_fill(fill);
      decode(make_win(s + 48, 8, fill), "R3", s, 8, 0);
    end
  endtask

  task automatic t_eight_hi; // R4 and R6
    for (int s = 280; s <= 287; s++) begin
      fill = next_fill(fill);
      decode(make_win(s - 280 + 192, 8, fill), (s >= 286) ? "R6" : "R4",
             s, 8, (s >= 286) ? 1 : 0);
    end
  endtask

  task automatic t_nine; // R5
    for (int s = 144; s <= 255; s++) begin
      fill = next_fill(fill);
      decode(make_win(s - 144 + 400, 9, fill), "R5", s, 9, 0);
    end
  endtask

  task automatic t_upper_ignored; // R1: same code, extreme trailing bits
    decode(make_win(5, 7, '0), "R1", 261, 7, 0);
    decode(make_win(5, 7, '1), "R1", 261, 7, 0);
    decode(make_win(100, 8, 16'h5500), "R1", 52, 8, 0);
    decode(make_win(100, 8, 16'hAAFF), "R1", 52, 8, 0);
    decode(make_win(511, 9, '0), "R1", 255, 9, 0);
    decode(make_win(511, 9, 16'hFE00), "R1", 255, 9, 0);
  endtask

  task automatic t_hold; // R7
    decode(make_win(198, 8, '0), "R7", 286, 8, 1);
    @(negedge clk);
    win = make_win(0, 7, '0); in_valid = 1'b0;
    @(negedge clk);
    check("R7", out_valid, 0, "out_valid idle");
    check("R7", out_sym, 286, "held symbol");
    check("R7", out_len, 8, "held length");
    check("R7", out_bad, 1, "held flag");
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_seven();
    t_eight_lo();
    t_eight_hi();
    t_nine();
    t_upper_ignored();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule